// File: doc/BRIEF.md
# Flag-Driven Context-Switch Microsequencer

This block runs a short microprogram that saves an engine's register state into context memory or restores it from there. The program sits in a 256-word instruction store. Software fills the store by writing a start index once and then writing instruction words back to back; the index steps forward by one after each word. A start pulse runs the program from address 0. The program stops when it reaches the end command.

Every instruction either works on one bit of a 128-entry flag file, jumps, loads a 20-bit length register, moves a run of consecutive engine registers, or issues a fixed command. A flag can be tested by a branch, waited on, or written. The instruction does not choose the direction of a block move. Flag 0 chooses it: when the flag is 1, registers are copied out to context memory, and when it is 0, context memory is copied into the registers. Each word moved advances a context position pointer by one. A command loads that pointer from the length register. Several flags are live inputs rather than stored bits: the engine-busy flag, the two automatic save and load request flags, and a constant-one flag.

Top module: `ctxseq`

## Requirements
- R1: When `progIdxWe` is high, `progWdata[7:0]` is loaded as the store write index. Each `progDataWe` writes `progWdata` to the store at that index and then adds one to the index.
- R2: After reset, `busy` is 0, `pc` is 0, `ctxAddr` is 0 and every stored flag is 0. A `start` pulse sets `busy` and `pc` to 0 in the next cycle, and any instruction decoded in that same cycle has no effect. Command word 0x0060000E clears `busy` and leaves `pc` unchanged. While idle, no transfer enable and no command pulse is driven.
- R3: The instruction class is in bits 23:20. Class 0x4 is a branch to the address in bits 15:8 that tests the flag numbered in bits 6:0. If bit 7 is 0 the branch is taken when the flag is 1; if bit 7 is 1 it is taken when the flag is 0. When the branch is not taken, `pc` advances by one.
- R4: Class 0x5 holds `pc` until the flag numbered in bits 6:0 equals bit 7. In the cycle where it does, `pc` advances.
- R5: Class 0x7 writes bit 7 into the flag numbered in bits 6:0. Flag 96 always reflects `engBusy`, flag 100 reflects `autoSave`, flag 101 reflects `autoLoad` and flag 104 reads 1. Writes to any of these four flags are ignored.
- R6: A high `userSaveSet` sets flag 5 and a high `userLoadSet` sets flag 6. Either one takes precedence over a class 0x7 write to the same flag in the same cycle.
- R7: Class 0x2 loads bits 19:0 into the length register. Command 0x0060000A copies the length register into the context pointer `ctxAddr`.
- R8: Class 0x1 moves N = bits 19:14 registers, starting at the 14-bit index in bits 13:0 and wrapping modulo 2^14, one word per cycle. With flag 0 = 1, each cycle asserts `regRdEn` and `ctxWrEn` and drives `ctxWrData` = `regRdData`. Each word moved adds one to `ctxAddr`.
- R9: With flag 0 = 0, a transfer asserts `ctxRdEn` and `regWrEn` each cycle and drives `regWrData` = `ctxRdData`. Register indices and `ctxAddr` advance exactly as in R8.
- R10: A class 0x1 instruction with a count of zero takes one cycle, moves nothing and leaves `ctxAddr` unchanged.
- R11: Command 0x00600007 gives a one-cycle pulse on `cmdNextSwap`, and command 0x00600009 gives a one-cycle pulse on `cmdNextCur`.
- R12: Classes other than 0x1, 0x2, 0x4, 0x5, 0x6 and 0x7, and class 0x6 words other than the four named commands, each complete in one cycle as no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| progIdxWe | input | 1 | Load the store write index from progWdata |
| progDataWe | input | 1 | Write progWdata into the store and step the index |
| progWdata | input | 32 | Index or instruction word from software |
| start | input | 1 | Run the program from address 0 |
| userSaveSet | input | 1 | Set flag 5 |
| userLoadSet | input | 1 | Set flag 6 |
| engBusy | input | 1 | Engine busy, read as flag 96 |
| autoSave | input | 1 | Automatic save request, read as flag 100 |
| autoLoad | input | 1 | Automatic load request, read as flag 101 |
| busy | output | 1 | Program running |
| pc | output | 8 | Address of the instruction being executed |
| flags | output | 128 | Current flag values, including the live inputs |
| cmdNextSwap | output | 1 | Next-to-swap command pulse |
| cmdNextCur | output | 1 | Next-to-current command pulse |
| regAddr | output | 14 | Engine register index for the transfer |
| regRdEn | output | 1 | Read the engine register (save) |
| regRdData | input | 32 | Engine register read data, combinational |
| regWrEn | output | 1 | Write the engine register (restore) |
| regWrData | output | 32 | Engine register write data |
| ctxAddr | output | 20 | Context position pointer |
| ctxRdEn | output | 1 | Read context memory (restore) |
| ctxRdData | input | 32 | Context memory read data, combinational |
| ctxWrEn | output | 1 | Write context memory (save) |
| ctxWrData | output | 32 | Context memory write data |

## Verification
The assertions check five things on every cycle:
- a start pulse lands on address 0 with the block running;
- an idle block drives no transfer or command;
- every word moved advances the context pointer by exactly one;
- a wait that is not yet satisfied holds the program counter, and a taken branch lands on its target;
- the end command stops the block.

Other behaviour depends on whole instruction sequences, and only the bench's scenarios can show it:
- index wrap during a block move;
- flag 0 switching the direction between two moves;
- writes to read-only flags being ignored;
- a request pulse winning over a same-cycle clear;
- the number of cycles spent on no-op opcodes.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

  parameter int INSTR_W   = 32;
  parameter int REG_IDX_W = 14;
  parameter int CNT_W     = 6;
  parameter int LEN_W     = 20;
  parameter int FLAG_N    = 128;
  parameter int FLAG_IDX_W = $clog2(FLAG_N);

  // Class codes in bits 23:20
  typedef enum logic [3:0] {
    CLS_XFER = 4'h1,
    CLS_LEN  = 4'h2,
    CLS_BRA  = 4'h4,
    CLS_WAIT = 4'h5,
    CLS_CMD  = 4'h6,
    CLS_SET  = 4'h7
  } opClass_e;

  parameter logic [INSTR_W-1:0] CMD_NEXT_SWAP = 32'h0060_0007;
  parameter logic [INSTR_W-1:0] CMD_NEXT_CUR  = 32'h0060_0009;
  parameter logic [INSTR_W-1:0] CMD_SET_PTR   = 32'h0060_000A;
  parameter logic [INSTR_W-1:0] CMD_FINISH    = 32'h0060_000E;

  parameter int FLAG_DIR     = 0;
  parameter int FLAG_USAVE   = 5;
  parameter int FLAG_ULOAD   = 6;
  parameter int FLAG_ENGBUSY = 96;
  parameter int FLAG_ASAVE   = 100;
  parameter int FLAG_ALOAD   = 101;
  parameter int FLAG_ONE     = 104;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  xferGo;
    logic [REG_IDX_W-1:0]  regIdx;
    logic                  lenLoad;
    logic                  ptrLoad;
    logic                  flagWr;
    logic [FLAG_IDX_W-1:0] flagNum;
    logic                  flagVal;
  } ctlStrobe_t;

endpackage

// File: rtl/ctxseq_ctrl.sv
module ctxseq_ctrl
  import ctxseq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [FLAG_N-1:0]   flags,
  output logic [PC_W-1:0]     pc,
  output logic                busy,
  output ctlStrobe_t          stb,
  output logic                cmdNextSwap,
  output logic                cmdNextCur
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_XFER} seqState_e;

  seqState_e            state, nState;
  logic [PC_W-1:0]      nPc;
  logic [CNT_W-1:0]     xferLeft, nLeft;
  logic [REG_IDX_W-1:0] xferIdx, nIdx;

  logic [3:0]            cls;
  logic [FLAG_IDX_W-1:0] fNum;
  logic                  fHit;
  logic [CNT_W-1:0]      cnt;
  logic                  taken;

  assign cls   = instr[23:20];
  assign fNum  = instr[FLAG_IDX_W-1:0];
  assign fHit  = flags[fNum];
  assign cnt   = instr[REG_IDX_W +: CNT_W];
  assign taken = instr[7] ? !fHit : fHit;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pc       <= '0;
      xferLeft <= '0;
      xferIdx  <= '0;
    end else begin
      state    <= nState;
      pc       <= nPc;
      xferLeft <= nLeft;
      xferIdx  <= nIdx;
    end
  end

  always_comb begin
    nState      = state;
    nPc         = pc;
    nLeft       = xferLeft;
    nIdx        = xferIdx;
    stb         = '0;
    cmdNextSwap = 1'b0;
    cmdNextCur  = 1'b0;

    case (state)
      ST_RUN: begin
        case (cls)
          CLS_XFER: begin
            if (cnt != '0) begin
              stb.xferGo = 1'b1;
              stb.regIdx = instr[REG_IDX_W-1:0];
              nIdx       = instr[REG_IDX_W-1:0] + 1'b1;
              nLeft      = cnt - 1'b1;
              if (cnt == CNT_W'(1)) nPc = pc + 1'b1;
              else                  nState = ST_XFER;
            end else begin
              nPc = pc + 1'b1;
            end
          end
          CLS_LEN: begin
            stb.lenLoad = 1'b1;
            nPc         = pc + 1'b1;
          end
          CLS_BRA: begin
            nPc = taken ? instr[8 +: PC_W] : pc + 1'b1;
          end
          CLS_WAIT: begin
            if (fHit == instr[7]) nPc = pc + 1'b1;
          end
          CLS_CMD: begin
            if (instr == CMD_FINISH) begin
              nState = ST_IDLE;
            end else begin
              cmdNextSwap = (instr == CMD_NEXT_SWAP);
              cmdNextCur  = (instr == CMD_NEXT_CUR);
              stb.ptrLoad = (instr == CMD_SET_PTR);
              nPc         = pc + 1'b1;
            end
          end
          CLS_SET: begin
            stb.flagWr  = 1'b1;
            stb.flagNum = fNum;
            stb.flagVal = instr[7];
            nPc         = pc + 1'b1;
          end
          default: nPc = pc + 1'b1;
        endcase
      end
      ST_XFER: begin
        stb.xferGo = 1'b1;
        stb.regIdx = xferIdx;
        nIdx       = xferIdx + 1'b1;
        nLeft      = xferLeft - 1'b1;
        if (xferLeft == CNT_W'(1)) begin
          nState = ST_RUN;
          nPc    = pc + 1'b1;
        end
      end
      default: ;
    endcase

    // A start pulse overrides whatever is decoded this cycle
    if (start) begin
      nState      = ST_RUN;
      nPc         = '0;
      stb         = '0;
      cmdNextSwap = 1'b0;
      cmdNextCur  = 1'b0;
    end
  end

endmodule

// File: rtl/ctxseq_dpath.sv
module ctxseq_dpath
  import ctxseq_pkg::*;
#(
  parameter int STORE_DEPTH = 256,
  parameter int DATA_W      = 32,
  parameter int PC_W        = $clog2(STORE_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 progIdxWe,
  input  logic                 progDataWe,
  input  logic [INSTR_W-1:0]   progWdata,
  input  ctlStrobe_t           stb,
  input  logic [PC_W-1:0]      pc,
  input  logic                 userSaveSet,
  input  logic                 userLoadSet,
  input  logic                 engBusy,
  input  logic                 autoSave,
  input  logic                 autoLoad,
  output logic [INSTR_W-1:0]   instr,
  output logic [FLAG_N-1:0]    flags,
  output logic [REG_IDX_W-1:0] regAddr,
  output logic                 regRdEn,
  input  logic [DATA_W-1:0]    regRdData,
  output logic                 regWrEn,
  output logic [DATA_W-1:0]    regWrData,
  output logic [LEN_W-1:0]     ctxAddr,
  output logic                 ctxRdEn,
  input  logic [DATA_W-1:0]    ctxRdData,
  output logic                 ctxWrEn,
  output logic [DATA_W-1:0]    ctxWrData
);

  // Instruction store with auto-stepping write index
  logic [INSTR_W-1:0] store [STORE_DEPTH];
  logic [PC_W-1:0]    wrIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wrIdx <= '0;
    else if (progIdxWe)  wrIdx <= progWdata[PC_W-1:0];
    else if (progDataWe) wrIdx <= wrIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (progDataWe && !progIdxWe) store[wrIdx] <= progWdata;
  end

  assign instr = store[pc];

  // Flag file: live inputs, constant one, or stored bits
  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    if (i == FLAG_ENGBUSY) begin : gLiveBusy
      assign flags[i] = engBusy;
    end else if (i == FLAG_ASAVE) begin : gLiveAsave
      assign flags[i] = autoSave;
    end else if (i == FLAG_ALOAD) begin : gLiveAload
      assign flags[i] = autoLoad;
    end else if (i == FLAG_ONE) begin : gConst
      assign flags[i] = 1'b1;
    end else begin : gStored
      logic bitQ;
      logic reqSet;
      if (i == FLAG_USAVE) begin : gUs
        assign reqSet = userSaveSet;
      end else if (i == FLAG_ULOAD) begin : gUl
        assign reqSet = userLoadSet;
      end else begin : gNone
        assign reqSet = 1'b0;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          bitQ <= 1'b0;
        else if (reqSet)
          bitQ <= 1'b1;
        else if (stb.flagWr && (stb.flagNum == FLAG_IDX_W'(i)))
          bitQ <= stb.flagVal;
      end
      assign flags[i] = bitQ;
    end
  end

  // Length register and context position pointer
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] ctxPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      ctxPtr <= '0;
    end else begin
      if (stb.lenLoad) lenReg <= progLen(stb, lenReg);
      if (stb.ptrLoad)     ctxPtr <= lenReg;
      else if (stb.xferGo) ctxPtr <= ctxPtr + 1'b1;
    end
  end

  // The length value travels in the instruction word
  logic [LEN_W-1:0] lenField;
  assign lenField = instr[LEN_W-1:0];

  function automatic logic [LEN_W-1:0] progLen(input ctlStrobe_t s,
                                                input logic [LEN_W-1:0] cur);
    return s.lenLoad ? lenField : cur;
  endfunction

  // Transfer steering: flag 0 picks the direction
  logic saveDir;
  assign saveDir   = flags[FLAG_DIR];
  assign regAddr   = stb.regIdx;
  assign ctxAddr   = ctxPtr;
  assign regRdEn   = stb.xferGo &&  saveDir;
  assign ctxWrEn   = stb.xferGo &&  saveDir;
  assign regWrEn   = stb.xferGo && !saveDir;
  assign ctxRdEn   = stb.xferGo && !saveDir;
  assign ctxWrData = regRdData;
  assign regWrData = ctxRdData;

endmodule

// File: rtl/ctxseq.sv
module ctxseq
  import ctxseq_pkg::*;
#(
  parameter int STORE_DEPTH = 256,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progIdxWe,
  input  logic              progDataWe,
  input  logic [31:0]       progWdata,
  input  logic              start,
  input  logic              userSaveSet,
  input  logic              userLoadSet,
  input  logic              engBusy,
  input  logic              autoSave,
  input  logic              autoLoad,
  output logic              busy,
  output logic [7:0]        pc,
  output logic [127:0]      flags,
  output logic              cmdNextSwap,
  output logic              cmdNextCur,
  output logic [13:0]       regAddr,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic [19:0]       ctxAddr,
  output logic              ctxRdEn,
  input  logic [DATA_W-1:0] ctxRdData,
  output logic              ctxWrEn,
  output logic [DATA_W-1:0] ctxWrData
);

  localparam int PC_W = $clog2(STORE_DEPTH);

  ctlStrobe_t         stb;
  logic [INSTR_W-1:0] instr;

  ctxseq_ctrl #(.PC_W(PC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .flags(flags),
    .pc(pc), .busy(busy), .stb(stb),
    .cmdNextSwap(cmdNextSwap), .cmdNextCur(cmdNextCur)
  );

  ctxseq_dpath #(.STORE_DEPTH(STORE_DEPTH), .DATA_W(DATA_W), .PC_W(PC_W)) uDpath (
    .clk(clk), .rstN(rstN), .progIdxWe(progIdxWe), .progDataWe(progDataWe),
    .progWdata(progWdata), .stb(stb), .pc(pc),
    .userSaveSet(userSaveSet), .userLoadSet(userLoadSet),
    .engBusy(engBusy), .autoSave(autoSave), .autoLoad(autoLoad),
    .instr(instr), .flags(flags),
    .regAddr(regAddr), .regRdEn(regRdEn), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .ctxAddr(ctxAddr), .ctxRdEn(ctxRdEn), .ctxRdData(ctxRdData),
    .ctxWrEn(ctxWrEn), .ctxWrData(ctxWrData)
  );

endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic [7:0]   pc,
  input logic [31:0]  instr,
  input logic [127:0] flags,
  input logic         regRdEn,
  input logic         regWrEn,
  input logic         ctxRdEn,
  input logic         ctxWrEn,
  input logic         cmdNextSwap,
  input logic         cmdNextCur,
  input logic [19:0]  ctxAddr
);

  logic waitOpen, braTaken;
  assign waitOpen = busy && !start && (instr[23:20] == 4'h5) &&
                    (flags[instr[6:0]] != instr[7]);
  assign braTaken = busy && !start && (instr[23:20] == 4'h4) &&
                    (flags[instr[6:0]] != instr[7]);

  // R2
  start_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && pc == 8'd0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(regRdEn || regWrEn || ctxRdEn || ctxWrEn || cmdNextSwap || cmdNextCur));

  // R2
  finish_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start && instr == 32'h0060_000E) |=> !busy);

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctxWrEn || ctxRdEn) |=> ctxAddr == $past(ctxAddr) + 20'd1);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitOpen |=> (busy && pc == $past(pc)));

  // R3
  branch_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    braTaken |=> pc == $past(instr[15:8]));

  // R11
  single_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdNextSwap, cmdNextCur, (regRdEn || regWrEn)}));

endmodule

bind ctxseq ctxseq_chk uChk (.*);

// File: tb/ctxseq_test.sv
module ctxseq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progIdxWe = 0, progDataWe = 0;
  logic [31:0] progWdata = '0;
  logic start = 0, userSaveSet = 0, userLoadSet = 0;
  logic engBusy = 0, autoSave = 0, autoLoad = 0;
  logic busy, cmdNextSwap, cmdNextCur;
  logic [7:0] pc;
  logic [127:0] flags;
  logic [13:0] regAddr;
  logic regRdEn, regWrEn, ctxRdEn, ctxWrEn;
  logic [31:0] regRdData, regWrData, ctxRdData, ctxWrData;
  logic [19:0] ctxAddr;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] regPat(input logic [13:0] a);
    return 32'hA5A5_0000 ^ {18'd0, a};
  endfunction
  function automatic logic [31:0] ctxPat(input logic [19:0] a);
    return 32'h5A5A_0000 ^ {12'd0, a};
  endfunction

  assign regRdData = regPat(regAddr);
  assign ctxRdData = ctxPat(ctxAddr);

  ctxseq uut (.*);

  int nChecks = 0, nErr = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0]  mmem [256];
  logic [7:0]   widx = 0, mpc = 0;
  bit           mrun = 0, mxfer = 0;
  logic [127:0] mflag = '0;
  logic [19:0]  mlen = 0, mptr = 0;
  int           mleft = 0;
  logic [13:0]  midx = 0;

  function automatic logic [127:0] effFlags();
    logic [127:0] f = mflag;
    f[96] = engBusy; f[100] = autoSave; f[101] = autoLoad; f[104] = 1'b1;
    return f;
  endfunction

  function automatic bit roFlag(input int f);
    return f == 96 || f == 100 || f == 101 || f == 104;
  endfunction

  always @(posedge clk) begin
    logic [31:0] w;
    logic [127:0] ef;
    int f, cnt;
    cyc++;
    if (!rstN) begin
      mpc = 0; mrun = 0; mxfer = 0; mflag = '0; mlen = 0; mptr = 0; widx = 0;
    end else begin
      w = mmem[mpc]; ef = effFlags(); f = int'(w[6:0]);
      if (start) begin
        mpc = 0; mrun = 1; mxfer = 0;
      end else if (mrun) begin
        if (mxfer) begin
          mptr++; midx++; mleft--;
          if (mleft == 0) begin mxfer = 0; mpc++; end
        end else begin
          case (w[23:20])
            4'h1: begin
              cnt = int'(w[19:14]);
              if (cnt == 0) mpc++;
              else begin
                mptr++; mleft = cnt - 1; midx = w[13:0] + 14'd1;
                if (mleft == 0) mpc++; else mxfer = 1;
              end
            end
            4'h2: begin mlen = w[19:0]; mpc++; end
            4'h4: mpc = ((w[7] ? !ef[f] : ef[f])) ? w[15:8] : mpc + 8'd1;
            4'h5: if (ef[f] == w[7]) mpc++;
            4'h6: begin
              if (w == 32'h0060_000E) mrun = 0;
              else begin
                if (w == 32'h0060_000A) mptr = mlen;
                mpc++;
              end
            end
            4'h7: begin if (!roFlag(f)) mflag[f] = w[7]; mpc++; end
            default: mpc++;
          endcase
        end
      end
      if (userSaveSet) mflag[5] = 1'b1;
      if (userLoadSet) mflag[6] = 1'b1;
      if (progIdxWe) widx = progWdata[7:0];
      else if (progDataWe) begin mmem[widx] = progWdata; widx++; end
    end
  end

  // Per-cycle comparison, mid-cycle
  int nCtxWr = 0, nRegWr = 0, nSwap = 0, nCur = 0, t6 = -1, t8 = -1;
  always @(negedge clk) begin
    logic [31:0] w;
    bit eX, eS, eC, dir;
    logic [13:0] eI;
    if (rstN && !finished) begin
      w = mmem[mpc]; eX = 0; eS = 0; eC = 0; eI = '0; dir = mflag[0];
      if (mrun && !start) begin
        if (mxfer) begin eX = 1; eI = midx; end
        else if (w[23:20] == 4'h1 && w[19:14] != 0) begin eX = 1; eI = w[13:0]; end
        else if (w[23:20] == 4'h6) begin
          eS = (w == 32'h0060_0007); eC = (w == 32'h0060_0009);
        end
      end
      chk(busy == mrun && pc == mpc, "R2 busy/pc", {busy, pc}, {mrun, mpc});
      chk(flags == effFlags(), "R5 flags", flags, effFlags());
      chk(ctxAddr == mptr, "R7 ctxAddr", ctxAddr, mptr);
      chk({regRdEn, ctxWrEn, regWrEn, ctxRdEn} == {eX && dir, eX && dir, eX && !dir, eX && !dir},
          "R8 enables", {regRdEn, ctxWrEn, regWrEn, ctxRdEn},
          {eX && dir, eX && dir, eX && !dir, eX && !dir});
      if (eX) begin
        chk(regAddr == eI, "R8 regAddr", regAddr, eI);
        if (dir) chk(ctxWrData == regPat(eI), "R8 save data", ctxWrData, regPat(eI));
        else     chk(regWrData == ctxPat(mptr), "R9 load data", regWrData, ctxPat(mptr));
      end
      chk({cmdNextSwap, cmdNextCur} == {eS, eC}, "R11 commands",
          {cmdNextSwap, cmdNextCur}, {eS, eC});
      if (ctxWrEn) nCtxWr++;
      if (regWrEn) nRegWr++;
      if (cmdNextSwap) nSwap++;
      if (cmdNextCur) nCur++;
      if (busy && pc == 8'd6 && t6 < 0) t6 = cyc;
      if (busy && pc == 8'd8 && t8 < 0) t8 = cyc;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadWord(input logic [31:0] v);
    progDataWe = 1; progWdata = v; tick(1); progDataWe = 0;
  endtask

  task automatic setIdx(input logic [7:0] i);
    progIdxWe = 1; progWdata = {24'd0, i}; tick(1); progIdxWe = 0;
  endtask

  task automatic pulseStart();
    start = 1; tick(1); start = 0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 500 && busy; k++) tick(1);
  endtask

  function automatic logic [31:0] iXfer(input int c, input int b);
    return 32'h0010_0000 | (c << 14) | b;
  endfunction
  function automatic logic [31:0] iBra(input int t, input int clr, input int f);
    return 32'h0040_0000 | (t << 8) | (clr << 7) | f;
  endfunction
  function automatic logic [31:0] iWait(input int v, input int f);
    return 32'h0050_0000 | (v << 7) | f;
  endfunction
  function automatic logic [31:0] iSet(input int v, input int f);
    return 32'h0070_0000 | (v << 7) | f;
  endfunction

  logic [31:0] p1 [25];

  initial begin
    p1[0]  = iSet(1, 0);          p1[1]  = 32'h0020_0010;
    p1[2]  = 32'h0060_000A;       p1[3]  = iXfer(3, 14'h100);
    p1[4]  = iXfer(0, 5);         p1[5]  = 32'h0060_0007;
    p1[6]  = 32'h0080_0001;       p1[7]  = 32'h0060_0003;
    p1[8]  = iWait(0, 96);        p1[9]  = iBra(12, 0, 104);
    p1[10] = iSet(1, 7);          p1[11] = 32'h0060_000E;
    p1[12] = iSet(0, 0);          p1[13] = iXfer(2, 14'h3FFF);
    p1[14] = iSet(0, 104);        p1[15] = iSet(1, 96);
    p1[16] = iBra(20, 0, 100);    p1[17] = 32'h0060_000E;
    p1[18] = 32'h0060_000E;       p1[19] = 32'h0060_000E;
    p1[20] = iWait(1, 5);         p1[21] = iSet(0, 5);
    p1[22] = 32'h0060_0009;       p1[23] = iBra(11, 0, 6);
    p1[24] = 32'h0060_000E;

    tick(3);
    rstN = 1;
    @(negedge clk);
    chk(busy == 0 && pc == 0 && ctxAddr == 0 && flags[0] == 0, "R2 reset state",
        {busy, pc, ctxAddr}, 0);
    tick(1);

    // R1: load program 1 through the index/data port
    setIdx(8'd0);
    for (int i = 0; i < 25; i++) loadWord(p1[i]);
    engBusy = 1; autoSave = 1;
    pulseStart();
    tick(30);
    @(negedge clk);
    chk(busy && pc == 8'd8, "R4 wait holds on busy engine", pc, 8);
    engBusy = 0;
    tick(40);
    @(negedge clk);
    chk(busy && pc == 8'd20, "R4 wait holds for user save", pc, 20);
    userSaveSet = 1; tick(1); userSaveSet = 0;
    waitIdle();
    @(negedge clk);
    chk(!busy && pc == 8'd24, "R1 R2 program ran to finish", {busy, pc}, 24);
    chk(ctxAddr == 20'h15, "R7 R10 final pointer", ctxAddr, 20'h15);
    chk(nCtxWr == 3, "R8 words saved", nCtxWr, 3);
    chk(nRegWr == 2, "R9 words restored", nRegWr, 2);
    chk(nSwap == 1 && nCur == 1, "R11 command pulse count", {nSwap, nCur}, {32'd1, 32'd1});
    chk(flags[7] == 0 && flags[0] == 0, "R3 skipped set and branch", flags[7:0], 0);
    chk(flags[104] == 1 && flags[96] == engBusy, "R5 read-only flags", flags[104:96], 9'h100);
    chk(t8 - t6 == 2, "R12 no-op opcodes take one cycle", t8 - t6, 2);
    chk(flags[5] == 0, "R6 user save flag cleared by program", flags[5], 0);

    // R6: request wins over a same-cycle clear
    setIdx(8'd0);
    loadWord(iSet(0, 6));
    loadWord(32'h0060_000E);
    start = 1; tick(1); start = 0; userLoadSet = 1; tick(1); userLoadSet = 0;
    waitIdle();
    @(negedge clk);
    chk(flags[6] == 1, "R6 request precedence", flags[6], 1);
    pulseStart();
    waitIdle();
    @(negedge clk);
    chk(flags[6] == 0, "R5 set instruction clears flag", flags[6], 0);

    tick(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      nErr++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule